// File: doc/BRIEF.md
# Serial Sample Output Port

This block turns pairs of output samples from two receive channels into bit-serial streams. Channel A's in-phase and quadrature words go out on one data pin and channel B's on a second pin. The two pins share a bit clock, a frame strobe and a ready flag. Every word is 16 bits of two's complement, and the most significant bit goes first. A frame is the I word followed at once by the Q word, with no gap between them. Each bit lasts two system clock cycles, so the bit clock runs at half the system clock.

The upstream side offers one sample pair at a time on a valid/ready stream. The port holds one pair in a single-entry buffer while the previous frame shifts out. A buffered pair starts the next frame on the cycle after the last bit, so frames follow each other without a gap. There is no stall:
- `in_ready` is high exactly when the buffer is empty.
- A beat offered while `in_ready` is low is discarded, and a sticky overrun flag is set.

Software-style controls select the following:
- the bit clock launch edge;
- the frame strobe polarity and the ready polarity;
- per-word or per-pair framing;
- whether the pad drivers are enabled.

The ready flag marks the start of every frame, whether or not the pad drivers are enabled.

A second path receives the serial output of a downstream slave device, so that devices can be chained. It uses its own bit clock input, selects the capture edge, and starts a word pair only on a frame strobe. It delivers the I word and then the Q word, as one-cycle result pulses.

Top module: `sout_port`

## Requirements
- R1: Each frame sends 2×16 bits per pin, MSB first: the I word (bits 31..16 of the frame), then the Q word. Channel A goes on `ser_a` and channel B on `ser_b`. Each bit is held for two clock cycles. Both data pins are 0 while no frame is active.
- R2: While a frame is active, `ser_sck` equals `cfg_sck_pol` XOR (first cycle of the bit). With `cfg_sck_pol`=0, data changes together with a rising bit clock edge. With `cfg_sck_pol`=1, data changes together with a falling edge. When idle, `ser_sck` rests at `cfg_sck_pol`.
- R3: The frame strobe is active for the whole first bit of a word:
  - with `cfg_packed`=0, at the start of both the I word and the Q word;
  - with `cfg_packed`=1, at the start of the I word only.
  The strobe is active high when `cfg_fs_inv`=0 and active low when `cfg_fs_inv`=1.
- R4: `rdy` is active for exactly two clock cycles at the start of every frame. It is active high when `cfg_rdy_inv`=0 and active low when `cfg_rdy_inv`=1. It behaves the same whatever the value of `cfg_en`.
- R5: `ser_oe` (the pad driver enable for the data, bit clock and strobe pins) follows `cfg_en` and is low after reset. Frames are still produced while it is low.
- R6: `in_ready` is high exactly when the one-pair buffer is empty. An accepted pair starts a frame on the next cycle if the port is idle, or directly after the last bit of the current frame if it is not.
- R7: A beat with `in_valid` high while `in_ready` is low is dropped, never appears on the pins, and sets `overrun`. `overrun` stays set until reset.
- R8: During and after reset:
  - `in_ready` is 1;
  - `overrun` is 0;
  - the data pins are 0;
  - the strobe and ready flag are inactive;
  - `ser_sck` is at its idle level.
- R9: The chain receiver captures `slv_a`, `slv_b` and `slv_fs` on falling edges of `sck_in` when `cfg_slv_pol`=0, and on rising edges when `cfg_slv_pol`=1. It uses the polarity from `cfg_fs_inv` for the strobe. It applies a synchronizer delay first. Bits captured with no frame in progress and no active strobe are ignored. A strobe starts a 32-bit frame, MSB first. After 16 bits, `rx_valid` pulses for one cycle with the I words and `rx_is_q`=0. After 32 bits it pulses again with the Q words and `rx_is_q`=1.
- R10: A strobe seen while a received frame is in progress has no effect on word alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Enable pad drivers of the serial pins |
| cfg_sck_pol | input | 1 | 0: data launched on rising bit clock edge; 1: on falling edge |
| cfg_fs_inv | input | 1 | Frame strobe active low when 1 (outgoing and received) |
| cfg_rdy_inv | input | 1 | Ready flag active low when 1 |
| cfg_packed | input | 1 | 1: one strobe per I/Q pair; 0: one per word |
| cfg_slv_pol | input | 1 | Chain receiver capture edge: 0 falling, 1 rising |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Buffer empty, pair will be taken |
| in_a_i | input | 16 | Channel A in-phase word |
| in_a_q | input | 16 | Channel A quadrature word |
| in_b_i | input | 16 | Channel B in-phase word |
| in_b_q | input | 16 | Channel B quadrature word |
| ser_a | output | 1 | Channel A serial data |
| ser_b | output | 1 | Channel B serial data |
| ser_sck | output | 1 | Serial bit clock |
| ser_fs | output | 1 | Frame strobe |
| ser_oe | output | 1 | Pad driver enable for data, bit clock, strobe |
| rdy | output | 1 | Frame start flag |
| overrun | output | 1 | Sticky dropped-pair flag |
| sck_in | input | 1 | Bit clock from chained slave |
| slv_a | input | 1 | Slave channel A data |
| slv_b | input | 1 | Slave channel B data |
| slv_fs | input | 1 | Slave frame strobe |
| rx_valid | output | 1 | One-cycle pulse: received word ready |
| rx_is_q | output | 1 | Received word is the Q word |
| rx_a | output | 16 | Received channel A word |
| rx_b | output | 16 | Received channel B word |

## Verification
The bench offers a pair while a frame is already shifting, and then offers another while the buffer is still full. A design that accepts the third pair would overwrite the buffered pair or put a frame on the pins that was never accepted. A design with an off-by-one last-bit decode would leave a gap between frames or clip the final Q bit. Words of 0x8000, 0xFFFF, 0x0001 and 0x7FFE are sent with the launch edge and both polarities inverted, and with `cfg_en` low. A wrong sign bit, a swapped edge, a strobe on the Q word in packed mode, or a ready flag gated by the enable would each show on the pins at once. On the chain input, stray bits arrive before any strobe and extra strobes arrive inside a frame, under both capture edges. A receiver that restarts on every strobe would misalign its words.

// File: rtl/sout_pkg.sv
package sout_pkg;
  // Static framing controls shared by the serializer stages.
  typedef struct packed {
    logic sck_pol;   // launch edge select
    logic fs_inv;    // strobe active low
    logic rdy_inv;   // ready active low
    logic pk;        // one strobe per I/Q pair
  } sout_cfg_t;
endpackage

// File: rtl/sout_buf.sv
module sout_buf #(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     a_q,
  input  logic [W-1:0]     b_i,
  input  logic [W-1:0]     b_q,
  input  logic             take,
  output logic             full,
  output logic [2*W-1:0]   pair_a,
  output logic [2*W-1:0]   pair_b,
  output logic             overrun
);
  assign in_ready = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= 1'b0;
      pair_a  <= '0;
      pair_b  <= '0;
      overrun <= 1'b0;
    end else begin
      if (in_valid && !full) begin
        full   <= 1'b1;
        pair_a <= {a_i, a_q};
        pair_b <= {b_i, b_q};
      end else if (take) begin
        full <= 1'b0;
      end
      if (in_valid && full) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/sout_ser.sv
module sout_ser
  import sout_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sout_cfg_t         cfg,
  input  logic              full,
  input  logic [2*W-1:0]    pair_a,
  input  logic [2*W-1:0]    pair_b,
  output logic              take,
  output logic              ser_a,
  output logic              ser_b,
  output logic              ser_sck,
  output logic              ser_fs,
  output logic              rdy
);
  localparam int FW = 2 * W;
  localparam int IW = $clog2(FW);

  logic          busy;
  logic          ph;     // 0: first half of bit, 1: second half
  logic [IW-1:0] idx;
  logic [FW-1:0] sh_a, sh_b;
  logic          last;
  logic          fs_act, rdy_act;

  assign last = busy && ph && (idx == IW'(FW - 1));
  assign take = full && (!busy || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ph   <= 1'b0;
      idx  <= '0;
      sh_a <= '0;
      sh_b <= '0;
    end else if (take) begin
      busy <= 1'b1;
      ph   <= 1'b0;
      idx  <= '0;
      sh_a <= pair_a;
      sh_b <= pair_b;
    end else if (busy) begin
      ph <= !ph;
      if (ph) begin
        if (last) begin
          busy <= 1'b0;
        end else begin
          idx  <= idx + IW'(1);
          sh_a <= sh_a << 1;
          sh_b <= sh_b << 1;
        end
      end
    end
  end

  assign fs_act  = busy && ((idx == '0) || (!cfg.pk && (idx == IW'(W))));
  assign rdy_act = busy && (idx == '0);

  assign ser_a   = busy & sh_a[FW-1];
  assign ser_b   = busy & sh_b[FW-1];
  assign ser_sck = cfg.sck_pol ^ (busy & !ph);
  assign ser_fs  = cfg.fs_inv ^ fs_act;
  assign rdy     = cfg.rdy_inv ^ rdy_act;
endmodule

// File: rtl/sout_chain_rx.sv
module sout_chain_rx #(
  parameter int W     = 16,
  parameter int SYNC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_rise,
  input  logic          fs_inv,
  input  logic          sck_in,
  input  logic          slv_a,
  input  logic          slv_b,
  input  logic          slv_fs,
  output logic          rx_valid,
  output logic          rx_is_q,
  output logic [W-1:0]  rx_a,
  output logic [W-1:0]  rx_b
);
  localparam int FW = 2 * W;
  localparam int CW = $clog2(FW + 1);

  // stage vector: {sck, fs, b, a}
  logic [3:0] sy [SYNC];
  logic [3:0] cur;
  logic       prev_sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy[0] <= '0;
    else        sy[0] <= {sck_in, slv_fs, slv_b, slv_a};
  end

  for (genvar k = 1; k < SYNC; k++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sy[k] <= '0;
      else        sy[k] <= sy[k-1];
    end
  end

  assign cur = sy[SYNC-1];

  logic          cap, fs_act, active;
  logic [CW-1:0] cnt, nc;
  logic [W-1:0]  sh_a, sh_b, nx_a, nx_b;

  assign cap    = cap_rise ? (cur[3] & !prev_sck) : (!cur[3] & prev_sck);
  assign fs_act = cur[2] ^ fs_inv;
  assign nc     = cnt + CW'(1);
  assign nx_a   = {sh_a[W-2:0], cur[0]};
  assign nx_b   = {sh_b[W-2:0], cur[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sck <= 1'b0;
      active   <= 1'b0;
      cnt      <= '0;
      sh_a     <= '0;
      sh_b     <= '0;
      rx_valid <= 1'b0;
      rx_is_q  <= 1'b0;
      rx_a     <= '0;
      rx_b     <= '0;
    end else begin
      prev_sck <= cur[3];
      rx_valid <= 1'b0;
      if (cap && (active || fs_act)) begin
        sh_a <= nx_a;
        sh_b <= nx_b;
        if (nc == CW'(FW)) begin
          active <= 1'b0;
          cnt    <= '0;
        end else begin
          active <= 1'b1;
          cnt    <= nc;
        end
        if (nc == CW'(W) || nc == CW'(FW)) begin
          rx_valid <= 1'b1;
          rx_is_q  <= (nc == CW'(FW));
          rx_a     <= nx_a;
          rx_b     <= nx_b;
        end
      end
    end
  end
endmodule

// File: rtl/sout_port.sv
module sout_port
  import sout_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_sck_pol,
  input  logic              cfg_fs_inv,
  input  logic              cfg_rdy_inv,
  input  logic              cfg_packed,
  input  logic              cfg_slv_pol,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a_i,
  input  logic [WORD_W-1:0] in_a_q,
  input  logic [WORD_W-1:0] in_b_i,
  input  logic [WORD_W-1:0] in_b_q,
  output logic              ser_a,
  output logic              ser_b,
  output logic              ser_sck,
  output logic              ser_fs,
  output logic              ser_oe,
  output logic              rdy,
  output logic              overrun,
  input  logic              sck_in,
  input  logic              slv_a,
  input  logic              slv_b,
  input  logic              slv_fs,
  output logic              rx_valid,
  output logic              rx_is_q,
  output logic [WORD_W-1:0] rx_a,
  output logic [WORD_W-1:0] rx_b
);
  localparam int FW = 2 * WORD_W;

  sout_cfg_t       cfg;
  logic            full, take;
  logic [FW-1:0]   pair_a, pair_b;

  assign cfg    = '{sck_pol: cfg_sck_pol, fs_inv: cfg_fs_inv,
                    rdy_inv: cfg_rdy_inv, pk: cfg_packed};
  assign ser_oe = cfg_en;

  sout_buf #(.W(WORD_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_i(in_a_i), .a_q(in_a_q), .b_i(in_b_i), .b_q(in_b_q),
    .take(take), .full(full), .pair_a(pair_a), .pair_b(pair_b),
    .overrun(overrun)
  );

  sout_ser #(.W(WORD_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .full(full),
    .pair_a(pair_a), .pair_b(pair_b), .take(take),
    .ser_a(ser_a), .ser_b(ser_b), .ser_sck(ser_sck),
    .ser_fs(ser_fs), .rdy(rdy)
  );

  sout_chain_rx #(.W(WORD_W), .SYNC(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .cap_rise(cfg_slv_pol), .fs_inv(cfg_fs_inv),
    .sck_in(sck_in), .slv_a(slv_a), .slv_b(slv_b), .slv_fs(slv_fs),
    .rx_valid(rx_valid), .rx_is_q(rx_is_q), .rx_a(rx_a), .rx_b(rx_b)
  );
endmodule

// File: rtl/sout_port_chk.sv
module sout_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_fs_inv,
  input logic cfg_rdy_inv,
  input logic cfg_packed,
  input logic in_valid,
  input logic in_ready,
  input logic overrun,
  input logic ser_sck,
  input logic ser_fs,
  input logic rdy,
  input logic rx_valid
);
  logic ract, fs_act;
  assign ract   = rdy ^ cfg_rdy_inv;
  assign fs_act = ser_fs ^ cfg_fs_inv;

  // R7
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready |=> overrun);
  // R7
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R4
  rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ract) |=> ract);
  // R4
  rdy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ract) ##1 ract |=> !ract);
  // R3
  fs_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_packed && fs_act |-> ract);
  // R2
  sck_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ract |=> ser_sck != $past(ser_sck));
  // R9
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind sout_port sout_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_fs_inv(cfg_fs_inv), .cfg_rdy_inv(cfg_rdy_inv),
  .cfg_packed(cfg_packed), .in_valid(in_valid), .in_ready(in_ready),
  .overrun(overrun), .ser_sck(ser_sck), .ser_fs(ser_fs), .rdy(rdy),
  .rx_valid(rx_valid)
);

// File: tb/test_sout_port.sv
module test_sout_port;
  localparam int W  = 16;
  localparam int FW = 2 * W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_en = 0, cfg_sck_pol = 0, cfg_fs_inv = 0, cfg_rdy_inv = 0;
  logic cfg_packed = 1, cfg_slv_pol = 0;
  logic in_valid = 0;
  logic [W-1:0] in_a_i = 0, in_a_q = 0, in_b_i = 0, in_b_q = 0;
  logic sck_in = 0, slv_a = 0, slv_b = 0, slv_fs = 0;
  logic in_ready, ser_a, ser_b, ser_sck, ser_fs, ser_oe, rdy, overrun;
  logic rx_valid, rx_is_q;
  logic [W-1:0] rx_a, rx_b;

  sout_port i_sout_port (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_sck_pol(cfg_sck_pol),
    .cfg_fs_inv(cfg_fs_inv), .cfg_rdy_inv(cfg_rdy_inv), .cfg_packed(cfg_packed),
    .cfg_slv_pol(cfg_slv_pol), .in_valid(in_valid), .in_ready(in_ready),
    .in_a_i(in_a_i), .in_a_q(in_a_q), .in_b_i(in_b_i), .in_b_q(in_b_q),
    .ser_a(ser_a), .ser_b(ser_b), .ser_sck(ser_sck), .ser_fs(ser_fs),
    .ser_oe(ser_oe), .rdy(rdy), .overrun(overrun), .sck_in(sck_in),
    .slv_a(slv_a), .slv_b(slv_b), .slv_fs(slv_fs), .rx_valid(rx_valid),
    .rx_is_q(rx_is_q), .rx_a(rx_a), .rx_b(rx_b)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: queue of pending pairs, one cycle counter per frame.
  logic [FW-1:0] q_a[$], q_b[$];
  logic [FW-1:0] fa = 0, fb = 0;
  bit m_busy = 0, m_ovr = 0;
  int m_cnt = 0;
  logic [2*W:0] x_q[$];  // {is_q, a, b} expected from chain receiver

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_a.delete(); q_b.delete();
      m_busy = 0; m_ovr = 0; m_cnt = 0;
    end else begin
      bit ld, acc;
      ld  = (q_a.size() != 0) && (!m_busy || m_cnt == 4*W-1);
      acc = in_valid && (q_a.size() == 0);
      if (ld) begin
        fa = q_a.pop_front(); fb = q_b.pop_front();
        m_busy = 1; m_cnt = 0;
      end else if (m_busy) begin
        if (m_cnt == 4*W-1) m_busy = 0;
        else m_cnt++;
      end
      if (acc) begin
        q_a.push_back({in_a_i, in_a_q});
        q_b.push_back({in_b_i, in_b_q});
      end else if (in_valid) m_ovr = 1;
    end
  end

  always @(negedge clk) begin
    int bi;
    bit ph;
    bi = m_cnt / 2;
    ph = (m_cnt % 2) == 1;
    chk("R1 ser_a", 32'(ser_a), 32'(m_busy ? fa[FW-1-bi] : 1'b0));
    chk("R1 ser_b", 32'(ser_b), 32'(m_busy ? fb[FW-1-bi] : 1'b0));
    chk("R2 ser_sck", 32'(ser_sck), 32'(cfg_sck_pol ^ (m_busy && !ph)));
    chk("R3 ser_fs", 32'(ser_fs),
        32'(cfg_fs_inv ^ (m_busy && (bi == 0 || (!cfg_packed && bi == W)))));
    chk("R4 rdy", 32'(rdy), 32'(cfg_rdy_inv ^ (m_busy && bi == 0)));
    chk("R5 ser_oe", 32'(ser_oe), 32'(cfg_en));
    chk("R6 in_ready", 32'(in_ready), 32'(q_a.size() == 0));
    chk("R7 overrun", 32'(overrun), 32'(m_ovr));
    if (rx_valid) begin
      if (x_q.size() == 0) chk("R10 unexpected rx word", 32'(1), 32'(0));
      else begin
        logic [2*W:0] e;
        e = x_q.pop_front();
        chk("R9 rx_is_q", 32'(rx_is_q), 32'(e[2*W]));
        chk("R9 rx_a", 32'(rx_a), 32'(e[2*W-1:W]));
        chk("R9 rx_b", 32'(rx_b), 32'(e[W-1:0]));
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired (all requirements) actual=%0d expected<100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic present(logic [W-1:0] ai, aq, bi, bq);
    in_valid = 1; in_a_i = ai; in_a_q = aq; in_b_i = bi; in_b_q = bq;
    tick();
    in_valid = 0;
  endtask

  task automatic send_wait(logic [W-1:0] ai, aq, bi, bq);
    while (!in_ready) tick();
    present(ai, aq, bi, bq);
  endtask

  task automatic wait_idle();
    while (m_busy || q_a.size() != 0) tick();
    repeat (3) tick();
  endtask

  task automatic slv_bit(bit a, bit b, bit fs);
    sck_in = cfg_slv_pol ? 1'b0 : 1'b1;   // launch edge
    slv_a = a; slv_b = b; slv_fs = fs;
    repeat (4) tick();
    sck_in = cfg_slv_pol ? 1'b1 : 1'b0;   // capture edge
    repeat (4) tick();
  endtask

  task automatic slv_frame(logic [FW-1:0] a, logic [FW-1:0] b, bit extra_fs);
    x_q.push_back({1'b0, a[FW-1:W], b[FW-1:W]});
    x_q.push_back({1'b1, a[W-1:0], b[W-1:0]});
    for (int k = 0; k < FW; k++)
      slv_bit(a[FW-1-k], b[FW-1-k], k == 0 || (extra_fs && (k == 5 || k == W)));
    slv_fs = 0;
    repeat (6) tick();
  endtask

  initial begin
    // R8: reset state compared on every clock while held
    repeat (4) tick();
    rst_n = 1;
    repeat (2) tick();

    // R4, R5: pins disabled, ready flag still marks the frame
    send_wait(16'h1234, 16'hABCD, 16'h8001, 16'h7FFE);
    wait_idle();

    // R1, R6, R7: back-to-back frames, third pair dropped
    cfg_en = 1; tick();
    send_wait(16'h8000, 16'h7FFF, 16'hFFFF, 16'h0001);
    send_wait(16'h0F0F, 16'hF0F0, 16'hA5A5, 16'h5A5A);
    present(16'hDEAD, 16'hBEEF, 16'hCAFE, 16'hF00D);
    chk("R7 overrun flagged after dropped beat", 32'(overrun), 32'(1));
    wait_idle();

    // R2, R3, R4: per-word framing, falling launch edge, inverted strobe and ready
    cfg_packed = 0; cfg_sck_pol = 1; cfg_fs_inv = 1; cfg_rdy_inv = 1; tick();
    send_wait(16'hFFFF, 16'h8000, 16'h0001, 16'h0000);
    send_wait(16'h7FFE, 16'h4321, 16'hC3C3, 16'h3C3C);
    wait_idle();

    // R8: reset in the middle of a frame clears everything
    send_wait(16'h1111, 16'h2222, 16'h3333, 16'h4444);
    repeat (20) tick();
    rst_n = 0; repeat (3) tick();
    chk("R8 overrun cleared by reset", 32'(overrun), 32'(0));
    chk("R8 in_ready after reset", 32'(in_ready), 32'(1));
    rst_n = 1; repeat (2) tick();

    // R9, R10: chain receiver, falling capture edge
    cfg_fs_inv = 0; cfg_sck_pol = 0; cfg_rdy_inv = 0; cfg_packed = 1;
    cfg_slv_pol = 0; sck_in = 0; repeat (6) tick();
    slv_bit(1, 0, 0); slv_bit(0, 1, 0); slv_bit(1, 1, 0);   // no strobe: ignored
    slv_frame({16'h8001, 16'h7FFE}, {16'hFFFF, 16'h0000}, 1'b1);

    // R9, R10: rising capture edge
    cfg_slv_pol = 1; sck_in = 1; repeat (6) tick();
    slv_bit(0, 1, 0);
    slv_frame({16'hA5C3, 16'h1234}, {16'h5A3C, 16'hEDCB}, 1'b1);
    slv_frame({16'h0001, 16'h8000}, {16'hFFFE, 16'h4000}, 1'b0);

    repeat (10) tick();
    chk("R9 all received words delivered", 32'(x_q.size()), 32'(0));
    summary();
    $finish;
  end
endmodule